// File: doc/BRIEF.md
# Per-CPU Timer and Interprocessor Interrupt Control Register

This block holds one 64-bit control word shared by up to four processors. For each CPU it keeps a pending timer flag and a pending interprocessor flag, and it drives one timer interrupt line and one interprocessor interrupt line per CPU. A periodic tick raises the timer flag of every CPU. Software acknowledges a timer interrupt by writing a one to that CPU's timer field. Software sends an interprocessor interrupt by writing a one to the target's request field, and acknowledges it by writing a one to the target's clear field.

Interprocessor requests are counted per target CPU in a small saturating counter. The interprocessor line stays high until the number of clears has caught up with the number of requests. A single write may acknowledge timers, post requests and clear requests together, and these actions take effect in a fixed order. A read returns the stored word with the reading CPU's number merged into the two lowest bits.

Top module: `cpu_misc_irq_reg`

## Requirements
- R1: A read with size code 3 (64-bit) returns, on `rd_data_o` one cycle later, the register image before any same-cycle write, OR'd with `rd_cpu_i` in bits 1:0. A read with any other size code returns zero and pulses `err_o` one cycle later. `rd_data_o` holds its value between reads.
- R2: The image holds CPU i's timer flag in bit 4+i and CPU i's interprocessor flag in bit 8+i. `tmr_irq_o[i]` always equals the timer flag of CPU i.
- R3: A cycle with `tick_i` high sets the timer flag and timer line of every configured CPU. A CPU that is already pending stays pending.
- R4: A legal write with bit 4+i set clears CPU i's timer flag and line. If a tick arrives in the same cycle, the tick is applied after the clear and the flag ends set.
- R5: A legal write with bit 12+i set sets bit 8+i and increments CPU i's pending count. `ipi_irq_o[i]` rises when the count leaves zero.
- R6: A legal write with bit 8+i set clears bit 8+i and decrements a nonzero count. `ipi_irq_o[i]` falls only when the count reaches zero.
- R7: Within one write the steps are applied in this order: timer clear, then request, then interprocessor clear. A request and a clear for the same CPU in one write leave the flag at 0 and the count unchanged, except that a count saturated at 15 ends at 14.
- R8: A write is legal only if its size code is 3 and at least one of bits 15:4 is set. An illegal write changes nothing and pulses `err_o` one cycle later. With no access in a cycle, `err_o` is low one cycle later.
- R9: Each pending count is 4 bits wide. A request at 15 leaves it at 15, and a clear at 0 leaves it at 0.
- R10: Bits that belong to CPUs at or above `NUM_CPU` have no effect and read as 0. Bits 3:2 and 63:12 always read as 0.
- R11: Reset clears all flags, counts, interrupt lines, `rd_data_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic timer tick, one cycle per event |
| wr_en_i | input | 1 | Write strobe |
| wr_size_i | input | 2 | Write size code (0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) |
| wr_data_i | input | 12 | Bits 15:4 of the write word; all other bits of the word have no function |
| rd_en_i | input | 1 | Read strobe |
| rd_size_i | input | 2 | Read size code, same encoding as the write size code |
| rd_cpu_i | input | 2 | Number of the reading CPU |
| rd_data_o | output | 64 | Registered read data |
| tmr_irq_o | output | NUM_CPU | Timer interrupt line per CPU |
| ipi_irq_o | output | NUM_CPU | Interprocessor interrupt line per CPU |
| err_o | output | 1 | One-cycle pulse after an illegal access |

## Verification
The properties assume that a tick, a write and a read may all arrive in the same cycle, and that each input is held for exactly one sampled edge. Write-field checks are therefore stated only for legal writes, and the timer-clear check is excluded in cycles that also carry a tick. The random stimulus leans toward legal 64-bit writes with sparse field bits, so that the counters reach saturation and fall back to zero. It also mixes in empty writes, narrow sizes and bits of the unconfigured CPU, and it keeps every input stable from one falling edge to the next.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
   localparam int MAX_CPU = 4;
   localparam int ID_W    = 2;
   localparam int FLD_LO  = 4;
   localparam int FLD_HI  = 15;
   localparam int TMR_OFS = 0;   // timer acknowledge nibble, relative to FLD_LO
   localparam int ICL_OFS = 4;   // interprocessor clear nibble
   localparam int IRQ_OFS = 8;   // interprocessor request nibble

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } acc_size_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
   import ipr_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic                  wr_en_i,
   input  logic [1:0]            wr_size_i,
   input  logic [FLD_HI:FLD_LO]  wr_data_i,
   output logic                  legal_o,
   output logic                  bad_o,
   output logic [NUM_CPU-1:0]    tclr_o,
   output logic [NUM_CPU-1:0]    req_o,
   output logic [NUM_CPU-1:0]    iclr_o
);
   logic size_ok;
   logic any_fld;

   assign size_ok = (wr_size_i == SZ_DBL);
   assign any_fld = |wr_data_i;
   assign legal_o = wr_en_i && size_ok && any_fld;
   assign bad_o   = wr_en_i && !(size_ok && any_fld);

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      assign tclr_o[i] = legal_o && wr_data_i[FLD_LO + TMR_OFS + i];
      assign iclr_o[i] = legal_o && wr_data_i[FLD_LO + ICL_OFS + i];
      assign req_o[i]  = legal_o && wr_data_i[FLD_LO + IRQ_OFS + i];
   end
endmodule

// File: rtl/irq_tmr_slice.sv
module irq_tmr_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   output logic pend_o
);
   // clear first, then the tick: a same-cycle tick leaves the flag set
   always_ff @(posedge clk) begin
      if (!rst_n) pend_o <= 1'b0;
      else        pend_o <= (pend_o && !clr_i) || tick_i;
   end
endmodule

// File: rtl/irq_ipi_slice.sv
module irq_ipi_slice #(
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic clr_i,
   output logic flag_o,
   output logic line_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_req;
   logic [CNT_W-1:0] cnt_nxt;
   logic             flag_nxt;

   always_comb begin
      // request step, saturating at the top
      cnt_req = cnt_q;
      if (req_i && (cnt_q != CNT_MAX)) cnt_req = cnt_q + CNT_ONE;
      // clear step, never below zero
      cnt_nxt = cnt_req;
      if (clr_i && (cnt_req != '0)) cnt_nxt = cnt_req - CNT_ONE;
      flag_nxt = flag_o;
      if (req_i) flag_nxt = 1'b1;
      if (clr_i) flag_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_o <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         flag_o <= flag_nxt;
      end
   end

   assign line_o = (cnt_q != '0);
endmodule

// File: rtl/cpu_misc_irq_reg.sv
module cpu_misc_irq_reg
   import ipr_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int CNT_W   = 4,
   parameter int DATA_W  = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_size_i,
   input  logic [FLD_HI:FLD_LO] wr_data_i,
   input  logic                 rd_en_i,
   input  logic [1:0]           rd_size_i,
   input  logic [ID_W-1:0]      rd_cpu_i,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic [NUM_CPU-1:0]   tmr_irq_o,
   output logic [NUM_CPU-1:0]   ipi_irq_o,
   output logic                 err_o
);
   localparam int IMG_HI = FLD_LO + 2 * MAX_CPU;  // first always-zero bit

   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..4");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must lie in 1..8");
   end
   if (DATA_W < IMG_HI) begin : g_bad_dw
      $error("DATA_W too narrow for the register image");
   end

   logic                 wr_legal;
   logic                 wr_bad;
   logic [NUM_CPU-1:0]   tclr;
   logic [NUM_CPU-1:0]   req;
   logic [NUM_CPU-1:0]   iclr;
   logic [NUM_CPU-1:0]   ipi_flag;
   logic [MAX_CPU-1:0]   tmr_pad;
   logic [MAX_CPU-1:0]   ipf_pad;
   logic [DATA_W-1:0]    image;
   logic                 rd_ok;

   irq_wr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
      .wr_en_i   (wr_en_i),
      .wr_size_i (wr_size_i),
      .wr_data_i (wr_data_i),
      .legal_o   (wr_legal),
      .bad_o     (wr_bad),
      .tclr_o    (tclr),
      .req_o     (req),
      .iclr_o    (iclr)
   );

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      irq_tmr_slice u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick_i (tick_i),
         .clr_i  (tclr[i]),
         .pend_o (tmr_irq_o[i])
      );
      irq_ipi_slice #(.CNT_W(CNT_W)) u_ipi (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_i  (req[i]),
         .clr_i  (iclr[i]),
         .flag_o (ipi_flag[i]),
         .line_o (ipi_irq_o[i])
      );
   end

   assign tmr_pad = MAX_CPU'(tmr_irq_o);
   assign ipf_pad = MAX_CPU'(ipi_flag);
   assign image   = DATA_W'({ipf_pad, tmr_pad, 4'b0000});
   assign rd_ok   = (rd_size_i == SZ_DBL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data_o <= '0;
         err_o     <= 1'b0;
      end else begin
         err_o <= wr_bad || (rd_en_i && !rd_ok);
         if (rd_en_i) rd_data_o <= rd_ok ? (image | DATA_W'(rd_cpu_i)) : '0;
      end
   end

   // wr_legal is kept visible for the bound checker
   logic unused_ok;
   assign unused_ok = wr_legal;
endmodule

// File: rtl/irq_misc_chk.sv
module irq_misc_chk
   import ipr_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_i,
   input logic                 wr_en_i,
   input logic [1:0]           wr_size_i,
   input logic [FLD_HI:FLD_LO] wr_data_i,
   input logic                 rd_en_i,
   input logic [1:0]           rd_size_i,
   input logic [ID_W-1:0]      rd_cpu_i,
   input logic [DATA_W-1:0]    rd_data_o,
   input logic [NUM_CPU-1:0]   tmr_irq_o,
   input logic [NUM_CPU-1:0]   ipi_irq_o,
   input logic                 err_o
);
   logic lw;
   assign lw = wr_en_i && (wr_size_i == SZ_DBL) && (|wr_data_i);

   AST_RD_ID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i && rd_size_i == SZ_DBL |=> rd_data_o[1:0] == $past(rd_cpu_i)); // R1
   AST_RD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i && rd_size_i != SZ_DBL |=> rd_data_o == '0 && err_o); // R1
   AST_TICK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> &tmr_irq_o); // R3
   AST_TMR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      lw && !tick_i |=> (tmr_irq_o & $past(wr_data_i[FLD_LO +: NUM_CPU])) == '0); // R4
   AST_IPI_POST: assert property (@(posedge clk) disable iff (!rst_n)
      lw && wr_data_i[FLD_LO + ICL_OFS +: NUM_CPU] == '0 |=>
      (ipi_irq_o & $past(wr_data_i[FLD_LO + IRQ_OFS +: NUM_CPU]))
         == $past(wr_data_i[FLD_LO + IRQ_OFS +: NUM_CPU])); // R5
   AST_BAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && !lw |=> err_o && $stable(ipi_irq_o)); // R8
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i && !rd_en_i |=> !err_o); // R8
   AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |=> rd_data_o[DATA_W-1:FLD_LO + 2 * MAX_CPU] == '0 && rd_data_o[3:2] == 2'b00); // R10
endmodule

bind cpu_misc_irq_reg irq_misc_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .wr_en_i   (wr_en_i),
   .wr_size_i (wr_size_i),
   .wr_data_i (wr_data_i),
   .rd_en_i   (rd_en_i),
   .rd_size_i (rd_size_i),
   .rd_cpu_i  (rd_cpu_i),
   .rd_data_o (rd_data_o),
   .tmr_irq_o (tmr_irq_o),
   .ipi_irq_o (ipi_irq_o),
   .err_o     (err_o)
);

// File: tb/tb_cpu_misc_irq_reg.sv
module tb_cpu_misc_irq_reg;
   localparam int NC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_size_i = 2'd0;
   logic [15:4] wr_data_i = '0;
   logic        rd_en_i = 1'b0;
   logic [1:0]  rd_size_i = 2'd0;
   logic [1:0]  rd_cpu_i = 2'd0;
   logic [63:0] rd_data_o;
   logic [NC-1:0] tmr_irq_o;
   logic [NC-1:0] ipi_irq_o;
   logic        err_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   bit          m_tmr [4];
   bit          m_flg [4];
   int          m_cnt [4];
   logic [63:0] m_rd;

   always #10 clk = ~clk;

   cpu_misc_irq_reg #(.NUM_CPU(NC), .CNT_W(4), .DATA_W(64)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .wr_en_i(wr_en_i), .wr_size_i(wr_size_i), .wr_data_i(wr_data_i),
      .rd_en_i(rd_en_i), .rd_size_i(rd_size_i), .rd_cpu_i(rd_cpu_i),
      .rd_data_o(rd_data_o), .tmr_irq_o(tmr_irq_o), .ipi_irq_o(ipi_irq_o),
      .err_o(err_o)
   );

   function automatic logic [63:0] img();
      logic [63:0] v = '0;
      for (int i = 0; i < NC; i++) begin
         v[4 + i] = m_tmr[i];
         v[8 + i] = m_flg[i];
      end
      return v;
   endfunction

   function automatic logic [NC-1:0] exp_tmr();
      logic [NC-1:0] v;
      for (int i = 0; i < NC; i++) v[i] = m_tmr[i];
      return v;
   endfunction

   function automatic logic [NC-1:0] exp_ipi();
      logic [NC-1:0] v;
      for (int i = 0; i < NC; i++) v[i] = (m_cnt[i] != 0);
      return v;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_tmr[i] = 0; m_flg[i] = 0; m_cnt[i] = 0;
      end
      m_rd = '0;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag, input logic exp_err);
      chk({tag, " tmr"}, 64'(tmr_irq_o), 64'(exp_tmr()));
      chk({tag, " ipi"}, 64'(ipi_irq_o), 64'(exp_ipi()));
      chk({tag, " err"}, 64'(err_o), 64'(exp_err));
      chk({tag, " rd"}, rd_data_o, m_rd);
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic step(input string tag, input bit tk, input bit we, input logic [1:0] ws,
                       input logic [15:4] wd, input bit re, input logic [1:0] rs,
                       input logic [1:0] rc);
      bit legal;
      bit e_err;
      tick_i = tk; wr_en_i = we; wr_size_i = ws; wr_data_i = wd;
      rd_en_i = re; rd_size_i = rs; rd_cpu_i = rc;
      @(posedge clk);
      legal = we && ws == 2'd3 && (wd != '0);
      e_err = (we && !legal) || (re && rs != 2'd3);
      if (re) m_rd = (rs == 2'd3) ? (img() | 64'(rc)) : 64'd0;
      if (legal) begin
         for (int i = 0; i < NC; i++) begin
            if (wd[4 + i]) m_tmr[i] = 0;
            if (wd[12 + i]) begin
               m_flg[i] = 1;
               if (m_cnt[i] < 15) m_cnt[i]++;
            end
            if (wd[8 + i]) begin
               m_flg[i] = 0;
               if (m_cnt[i] > 0) m_cnt[i]--;
            end
         end
      end
      if (tk) for (int i = 0; i < NC; i++) m_tmr[i] = 1;
      @(negedge clk);
      tick_i = 0; wr_en_i = 0; rd_en_i = 0;
      check_all(tag, e_err);
   endtask

   task automatic wr(input string tag, input logic [15:4] wd);
      step(tag, 0, 1, 2'd3, wd, 0, 2'd3, 2'd0);
   endtask

   task automatic rd(input string tag, input logic [1:0] rc);
      step(tag, 0, 0, 2'd3, '0, 1, 2'd3, rc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0101));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      check_all("R11 reset", 0);

      rd("R1 id only", 2'd2);
      step("R3 tick", 1, 0, 2'd3, '0, 1, 2'd3, 2'd1);  // R1 read sees pre-tick image
      rd("R2 image", 2'd1);
      wr("R4 ack cpu1", 12'h002);
      step("R4 tick wins", 1, 1, 2'd3, 12'h001, 0, 2'd3, 2'd0);
      rd("R2 after ack", 2'd3);

      for (int k = 0; k < 3; k++) wr("R5 post cpu0", 12'h100);
      rd("R5 flag", 2'd0);
      wr("R6 clr cpu0 a", 12'h010);
      wr("R6 clr cpu0 b", 12'h010);
      wr("R6 clr cpu0 c", 12'h010);
      wr("R9 clr at zero", 12'h010);
      rd("R6 flag gone", 2'd0);

      for (int k = 0; k < 17; k++) wr("R9 saturate cpu1", 12'h200);
      for (int k = 0; k < 15; k++) wr("R9 drain cpu1", 12'h020);

      wr("R7 req+clr cpu2", 12'h440);
      rd("R7 flag after pair", 2'd2);
      for (int k = 0; k < 15; k++) wr("R9 fill cpu2", 12'h400);
      wr("R7 pair at max", 12'h440);
      step("R3 tick again", 1, 0, 2'd3, '0, 0, 2'd3, 2'd0);
      wr("R7 ack all + post cpu0", 12'h107);
      rd("R7 image", 2'd1);

      wr("R8 empty write", 12'h000);
      step("R8 narrow write", 0, 1, 2'd2, 12'h107, 0, 2'd3, 2'd0);
      step("R1 narrow read", 0, 0, 2'd3, '0, 1, 2'd1, 2'd3);
      step("R8 idle", 0, 0, 2'd3, '0, 0, 2'd3, 2'd0);

      wr("R10 cpu3 post", 12'h800);
      wr("R10 cpu3 ack", 12'h008);
      step("R10 tick", 1, 0, 2'd3, '0, 0, 2'd3, 2'd0);
      rd("R10 read", 2'd0);

      for (int n = 0; n < 600; n++) begin
         logic [31:0] r = $urandom;
         logic [31:0] s = $urandom;
         logic [1:0]  ws = (r[6:4] == 3'd0) ? r[8:7] : 2'd3;
         logic [1:0]  rs = (r[15:13] == 3'd0) ? r[17:16] : 2'd3;
         logic [15:4] wd = (r[11:9] == 3'd0) ? 12'h000 : (s[11:0] & s[23:12]);
         step("R2/R5/R6 random", (r[22:20] == 3'd0), r[3], ws, wd, r[12], rs, r[19:18]);
      end

      rst_n = 0;
      @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1;
      check_all("R11 mid reset", 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule